// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital controller that sits next to the analog front end of a dual-slope integrating converter. It drives four analog switch enables: integrator discharge, unknown-input connect, positive reference connect and negative reference connect. It reads a single comparator that reports whether the integrator output is above zero. The analog integrator, comparator and references are outside the block.

A conversion begins with a start pulse while the block is idle. The input is integrated for a fixed number of clocks. After a one-clock pause the comparator is sampled to learn the integrator's sign. The block then closes whichever reference drives the integrator back toward zero, and counts clocks until the comparator reports the crossing. The count, signed by the polarity, is the result, and a one-clock done strobe marks it. If no crossing arrives within the maximum run-down count, the result saturates and an overrange flag is raised. Every conversion ends with a discharge phase of configurable length before the block reports idle again. The same phase runs after reset. Only one switch is ever closed at a time, and an all-open clock separates any two different closed switches.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is held and for RST_CYC clocks after it is released, only the discharge switch is closed. One all-open clock follows, then busy goes low with done low, overrange low and the result zero.
- R2: A start pulse seen while idle closes the input switch from the next clock edge, for exactly RUNUP_CYC clocks.
- R3: In the all-open clock after run-up, the comparator is sampled. A high value (integrator above zero) selects the negative reference; a low value selects the positive reference.
- R4: Let n be the number of reference clocks after which the comparator first shows the crossing. For the negative reference the crossing is the integrator at or below zero; for the positive reference it is the integrator above zero. The result is +n with the negative reference and -n with the positive reference, in two's complement. The reference switch stays closed for n+1 clocks.
- R5: If n would exceed MAX_RD, the result is +MAX_RD or -MAX_RD with the sign rule of R4, overrange is high, and the reference switch stays closed for MAX_RD+1 clocks.
- R6: Done is high for exactly one clock per conversion. The result and overrange change only in that clock and hold their values until the next done.
- R7: At most one of the four switch enables is high in any clock.
- R8: Whenever the closed switch changes from one switch to a different one, at least one clock with all switches open lies between them.
- R9: After done, the discharge switch is closed for exactly RST_CYC clocks. Busy goes low only after that and one all-open clock. Busy is high from the clock after start until then.
- R10: A start pulse while busy is ignored. The run-up length and the result are unaffected, and no new run-up follows the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, honoured only while idle |
| cmp_pos_i | input | 1 | Comparator, high when the integrator is above zero |
| sw_in_o | output | 1 | Connect the unknown input to the integrator |
| sw_pref_o | output | 1 | Connect the positive reference |
| sw_nref_o | output | 1 | Connect the negative reference |
| sw_disch_o | output | 1 | Discharge the integrator capacitor |
| busy_o | output | 1 | Sequencer not idle |
| done_o | output | 1 | One-clock result strobe |
| ovr_o | output | 1 | Result saturated, no crossing within MAX_RD clocks |
| result_o | output | CNT_W+1 | Signed run-down count |

## Verification
The bench sweeps the input across both polarities, with a behavioural integrator. The sweep covers zero, which must pick the positive reference and give -1. It covers the largest input on each side that still crosses within MAX_RD, and the first input on each side that saturates. A design with an off-by-one in the run-down compare would report MAX_RD as overrange or miss the saturation by one count. A polarity inversion would run the integrator away from zero and saturate every conversion. The bench counts the clocks each switch is closed, so a stretched or shortened run-up or discharge shows up as a wrong count. It also watches for two switches closing back to back without a gap. A start pulse issued mid-conversion must leave the result and the phase lengths unchanged.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUNUP  = 3'd1,
    ST_SAMPLE = 3'd2,
    ST_RUNDN  = 3'd3,
    ST_GAP_DN = 3'd4,
    ST_DISCH  = 3'd5,
    ST_GAP_ID = 3'd6
  } seq_st_e;

  typedef struct packed {
    logic disch;
    logic nref;
    logic pref;
    logic inp;
  } sw_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Switch pattern that belongs to a given phase; use_nref picks the run-down side.
  function automatic sw_t sw_of(input seq_st_e st, input logic use_nref);
    sw_t s;
    s = '0;
    case (st)
      ST_RUNUP: s.inp   = 1'b1;
      ST_RUNDN: begin
        s.nref = use_nref;
        s.pref = ~use_nref;
      end
      ST_DISCH: s.disch = 1'b1;
      default:  s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dsadc_tick.sv
module dsadc_tick #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_o <= '0;
    end else if (inc_i) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/dsadc_pol.sv
module dsadc_pol (
  input  logic clk,
  input  logic rst,
  input  logic cap_i,
  input  logic cmp_pos_i,
  output logic use_nref_d_o,
  output logic use_nref_q_o,
  output logic crossed_o
);

  assign use_nref_d_o = cap_i ? cmp_pos_i : use_nref_q_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      use_nref_q_o <= 1'b0;
    end else begin
      use_nref_q_o <= use_nref_d_o;
    end
  end

  // With the negative reference the integrator falls, so the crossing shows as
  // the comparator going low; with the positive reference it shows as high.
  assign crossed_o = use_nref_q_o ? ~cmp_pos_i : cmp_pos_i;

endmodule

// File: rtl/dsadc_res.sv
module dsadc_res #(
  parameter int CNT_W  = 8,
  parameter int MAX_RD = 100,
  localparam int RES_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fin_i,
  input  logic             sat_i,
  input  logic             pos_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [RES_W-1:0] result_o,
  output logic             ovr_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_RD);

  logic [CNT_W-1:0] mag;
  logic [RES_W-1:0] mag_ext;

  assign mag     = sat_i ? MAX_V : cnt_i;
  assign mag_ext = {1'b0, mag};

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      ovr_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= fin_i;
      if (fin_i) begin
        result_o <= pos_i ? mag_ext : (~mag_ext + 1'b1);
        ovr_o    <= sat_i;
      end
    end
  end

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq #(
  parameter int RUNUP_CYC = 16,
  parameter int MAX_RD    = 20,
  parameter int RST_CYC   = 3,
  localparam int MAXV     = dsadc_pkg::max3(RUNUP_CYC, MAX_RD, RST_CYC),
  localparam int CNT_W    = $clog2(MAXV + 1),
  localparam int RES_W    = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cmp_pos_i,
  output logic             sw_in_o,
  output logic             sw_pref_o,
  output logic             sw_nref_o,
  output logic             sw_disch_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovr_o,
  output logic [RES_W-1:0] result_o
);
  import dsadc_pkg::*;

  localparam logic [CNT_W-1:0] UP_LAST = CNT_W'(RUNUP_CYC - 1);
  localparam logic [CNT_W-1:0] DS_LAST = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] RD_MAX  = CNT_W'(MAX_RD);

  seq_st_e          st_q, st_d;
  sw_t              sw_q;
  logic [CNT_W-1:0] cnt;
  logic             t_clr, t_inc, cap, fin, sat;
  logic             use_nref_d, use_nref_q, crossed;

  dsadc_tick #(.W(CNT_W)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clr_i (t_clr),
    .inc_i (t_inc),
    .cnt_o (cnt)
  );

  dsadc_pol u_pol (
    .clk          (clk),
    .rst          (rst),
    .cap_i        (cap),
    .cmp_pos_i    (cmp_pos_i),
    .use_nref_d_o (use_nref_d),
    .use_nref_q_o (use_nref_q),
    .crossed_o    (crossed)
  );

  dsadc_res #(.CNT_W(CNT_W), .MAX_RD(MAX_RD)) u_res (
    .clk      (clk),
    .rst      (rst),
    .fin_i    (fin),
    .sat_i    (sat),
    .pos_i    (use_nref_q),
    .cnt_i    (cnt),
    .result_o (result_o),
    .ovr_o    (ovr_o),
    .done_o   (done_o)
  );

  always_comb begin
    st_d  = st_q;
    t_clr = 1'b0;
    t_inc = 1'b0;
    cap   = 1'b0;
    fin   = 1'b0;
    sat   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d  = ST_RUNUP;
          t_clr = 1'b1;
        end
      end
      ST_RUNUP: begin
        if (cnt == UP_LAST) begin
          st_d  = ST_SAMPLE;
          t_clr = 1'b1;
        end else begin
          t_inc = 1'b1;
        end
      end
      ST_SAMPLE: begin
        cap   = 1'b1;
        st_d  = ST_RUNDN;
        t_clr = 1'b1;
      end
      ST_RUNDN: begin
        if (crossed) begin
          fin  = 1'b1;
          st_d = ST_GAP_DN;
        end else if (cnt == RD_MAX) begin
          fin  = 1'b1;
          sat  = 1'b1;
          st_d = ST_GAP_DN;
        end else begin
          t_inc = 1'b1;
        end
      end
      ST_GAP_DN: begin
        st_d  = ST_DISCH;
        t_clr = 1'b1;
      end
      ST_DISCH: begin
        if (cnt == DS_LAST) begin
          st_d  = ST_GAP_ID;
          t_clr = 1'b1;
        end else begin
          t_inc = 1'b1;
        end
      end
      ST_GAP_ID: st_d = ST_IDLE;
      default:   st_d = ST_DISCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_DISCH;
      sw_q   <= sw_of(ST_DISCH, 1'b0);
      busy_o <= 1'b1;
    end else begin
      st_q   <= st_d;
      sw_q   <= sw_of(st_d, use_nref_d);
      busy_o <= (st_d != ST_IDLE);
    end
  end

  assign sw_in_o    = sw_q.inp;
  assign sw_pref_o  = sw_q.pref;
  assign sw_nref_o  = sw_q.nref;
  assign sw_disch_o = sw_q.disch;

endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int RUNUP_CYC = 16,
  parameter int MAX_RD    = 20,
  parameter int RES_W     = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             sw_in_o,
  input logic             sw_pref_o,
  input logic             sw_nref_o,
  input logic             sw_disch_o,
  input logic             done_o,
  input logic             ovr_o,
  input logic [RES_W-1:0] result_o
);

  logic [3:0]  sw;
  logic [31:0] in_len;
  logic        saw_nref;

  assign sw = {sw_disch_o, sw_nref_o, sw_pref_o, sw_in_o};

  always_ff @(posedge clk) begin
    if (rst) begin
      in_len   <= '0;
      saw_nref <= 1'b0;
    end else begin
      in_len <= sw_in_o ? in_len + 1 : '0;
      if (sw_nref_o)      saw_nref <= 1'b1;
      else if (sw_pref_o) saw_nref <= 1'b0;
    end
  end

  p_one_switch_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sw));

  p_break_before_make_r8: assert property (@(posedge clk) disable iff (rst)
    ((|sw) && (|$past(sw))) |-> (sw == $past(sw)));

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(result_o) && $stable(ovr_o)));

  p_runup_len_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(sw_in_o) |-> (in_len == RUNUP_CYC));

  p_sign_by_ref_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (($signed(result_o) > 0) == saw_nref));

  p_saturate_r5: assert property (@(posedge clk) disable iff (rst)
    (done_o && ovr_o) |->
      (($signed(result_o) == MAX_RD) || ($signed(result_o) == -MAX_RD)));

endmodule

bind dsadc_seq dsadc_seq_chk #(
  .RUNUP_CYC (RUNUP_CYC),
  .MAX_RD    (MAX_RD),
  .RES_W     (RES_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sw_in_o    (sw_in_o),
  .sw_pref_o  (sw_pref_o),
  .sw_nref_o  (sw_nref_o),
  .sw_disch_o (sw_disch_o),
  .done_o     (done_o),
  .ovr_o      (ovr_o),
  .result_o   (result_o)
);

// File: tb/dsadc_seq_bench.sv
module dsadc_seq_bench;

  localparam int RUNUP = 16;
  localparam int MAXRD = 20;
  localparam int RSTC  = 3;
  localparam int REFV  = 12;
  localparam int RW    = $clog2(MAXRD + 1) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cmp_pos;
  logic sw_in, sw_pref, sw_nref, sw_disch, busy, done, ovr;
  logic [RW-1:0] result;

  int acc = 0;
  int vin = 0;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  dsadc_seq #(.RUNUP_CYC(RUNUP), .MAX_RD(MAXRD), .RST_CYC(RSTC)) u_dsadc_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .cmp_pos_i  (cmp_pos),
    .sw_in_o    (sw_in),
    .sw_pref_o  (sw_pref),
    .sw_nref_o  (sw_nref),
    .sw_disch_o (sw_disch),
    .busy_o     (busy),
    .done_o     (done),
    .ovr_o      (ovr),
    .result_o   (result)
  );

  // Behavioural integrator and comparator.
  always @(posedge clk) begin
    if (sw_disch)     acc <= 0;
    else if (sw_in)   acc <= acc + vin;
    else if (sw_nref) acc <= acc - REFV;
    else if (sw_pref) acc <= acc + REFV;
  end
  assign cmp_pos = (acc > 0);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog timeout");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic convert(input int v, input bit extra_start);
    int a, n, exp_res, exp_ovr, in_cyc, ref_cyc, pref_cyc, nref_cyc, dis_cyc;
    int gap_bad, cyc;
    logic [3:0] prev, cur;
    a = RUNUP * v;
    if (a > 0) n = (a + REFV - 1) / REFV;
    else       n = (-a) / REFV + 1;
    exp_ovr = (n > MAXRD) ? 1 : 0;
    if (exp_ovr == 1) n = MAXRD;
    exp_res = (a > 0) ? n : -n;
    vin = v;
    in_cyc = 0; pref_cyc = 0; nref_cyc = 0; dis_cyc = 0; gap_bad = 0; cyc = 0;
    prev = 4'b0000;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R9 busy after start", int'(busy), 1);
    while (!done && cyc < 200) begin
      cur = {sw_disch, sw_nref, sw_pref, sw_in};
      if ((cur != 0) && (prev != 0) && (cur != prev)) gap_bad++;
      if ($countones(cur) > 1) gap_bad++;
      prev = cur;
      if (sw_in)   in_cyc++;
      if (sw_pref) pref_cyc++;
      if (sw_nref) nref_cyc++;
      if (extra_start && cyc == 5) start = 1'b1;
      if (extra_start && cyc == 6) start = 1'b0;
      cyc++;
      @(negedge clk);
    end
    chk("R6 done seen", int'(done), 1);
    chk("R2 run-up clocks", in_cyc, RUNUP);
    ref_cyc = n + 1;
    chk("R3 negative reference clocks", nref_cyc, (a > 0) ? ref_cyc : 0);
    chk("R4 positive reference clocks", pref_cyc, (a > 0) ? 0 : ref_cyc);
    chk("R4 signed result", int'($signed(result)), exp_res);
    chk("R5 overrange flag", int'(ovr), exp_ovr);
    chk("R7 R8 switch exclusivity", gap_bad, 0);
    @(negedge clk);
    chk("R6 done one clock", int'(done), 0);
    cyc = 0;
    while (busy && cyc < 50) begin
      if (sw_disch) dis_cyc++;
      if (sw_in) gap_bad++;
      cyc++;
      @(negedge clk);
    end
    chk("R9 discharge clocks", dis_cyc, RSTC);
    chk("R6 result held", int'($signed(result)), exp_res);
    if (extra_start) begin
      repeat (8) begin
        if (sw_in || busy) gap_bad++;
        @(negedge clk);
      end
      chk("R10 start while busy ignored", gap_bad, 0);
    end
  endtask

  initial begin : stim
    int dcnt;
    repeat (3) @(negedge clk);
    chk("R1 discharge during reset", int'(sw_disch), 1);
    rst = 1'b0;
    dcnt = 0;
    while (sw_disch && dcnt < 50) begin
      dcnt++;
      @(negedge clk);
    end
    chk("R1 discharge clocks after reset", dcnt, RSTC);
    chk("R1 busy in gap", int'(busy), 1);
    @(negedge clk);
    chk("R1 idle busy", int'(busy), 0);
    chk("R1 idle done", int'(done), 0);
    chk("R1 idle ovr", int'(ovr), 0);
    chk("R1 idle result", int'(result), 0);
    chk("R1 idle switches", int'({sw_disch, sw_nref, sw_pref, sw_in}), 0);
    for (int v = -16; v <= 16; v++) convert(v, 1'b0);
    convert(7, 1'b1);
    convert(-9, 1'b1);
    convert(15, 1'b0);
    convert(0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule